// File: doc/BRIEF.md
# 64-bit Nanosecond Alarm Timer

This peripheral sits on a 32-bit register bus and decodes a 4 KiB window. It holds a free-running 64-bit time counter in nanoseconds. The counter advances by a fixed step on every clock. Software reads the time as two 32-bit words. The low-word read captures the whole 64-bit value into a snapshot, and the high-word read returns the upper half of that snapshot. The two halves therefore always belong to the same instant.

A one-shot alarm is loaded as two words: the upper half first, then the lower half. Writing the lower half arms the alarm. The new 64-bit value is compared, as a signed number, with the time in that cycle. If the alarm is already due, the interrupt is raised at once and the alarm is not armed. Otherwise the controller moves from state DISARMED to state ARMED. In ARMED it waits until the time reaches the alarm, then raises the interrupt and returns to DISARMED.

A separate register acknowledges the interrupt and leaves an armed alarm in place. Another register cancels the alarm and also drops the interrupt. The alarm controller has two states and these transitions:
- DISARMED to ARMED on a low-half write whose alarm is in the future.
- ARMED to DISARMED on a cancel write, on the alarm being reached, or on a low-half write whose new alarm is already due.
- ARMED to ARMED on a low-half write whose new alarm is in the future. This re-arms with the new value.

Top module: `alarm_timer64`

## Requirements
- R1: While reset is held and right after it, the interrupt, the error pulse and the read data are all zero. The time counter, snapshot, alarm value and armed state are also zero.
- R2: The counter starts at zero and grows by NS_PER_CLK on every clock. A read of offset 0x00 captures the 64-bit time of that cycle and returns its bits 31:0 on rd_data in the next cycle.
- R3: A read of offset 0x04 returns bits 63:32 of the snapshot taken by the latest 0x00 read, on rd_data in the next cycle. It does not return the live counter.
- R4: A write to offset 0x0C only stores the upper 32 alarm bits. It neither arms the alarm nor changes the interrupt.
- R5: A write to offset 0x08 stores the lower 32 bits. If the resulting alarm is less than or equal to the time in that cycle, the interrupt is high from the next cycle and the controller stays or goes DISARMED.
- R6: If that alarm is greater than the time, the controller goes ARMED. In the first cycle where the time is at least the alarm, the interrupt is set in the next cycle and the controller returns to DISARMED. The alarm never fires again by itself.
- R7: A write to offset 0x10 drops the interrupt in the next cycle and leaves an armed alarm armed. An alarm firing in the same cycle takes priority over the acknowledge.
- R8: A write to offset 0x14 drops the interrupt and returns the controller to DISARMED in the next cycle. An alarm due in that same cycle is discarded.
- R9: Only reads of 0x00 and 0x04 and writes of 0x08, 0x0C, 0x10 and 0x14 are valid. Any other access returns zero on a read and has no effect on a write. It also raises err for exactly the next cycle.
- R10: The alarm and the time compare as signed 64-bit numbers. An alarm whose bit 63 is set is always in the past at a small time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle it is high |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after a read access |
| irq | output | 1 | Level interrupt |
| err | output | 1 | One-cycle pulse after an unlisted access |

## Verification
The checker watches every cycle for several properties: the counter step, the high-half read returning the snapshot, and a high-half write leaving the controller idle. It also checks that a due armed alarm fires and disarms, that acknowledge and cancel take effect in the next cycle, and that err appears only after an access. Some outcomes depend on absolute time as software sees it, and only the bench's scenarios show them. These are the low-word value tracking the elapsed clocks, and the snapshot holding its upper half while a fast-stepping instance rolls past a 32-bit boundary. They also include an alarm firing in exactly the cycle it comes due after an acknowledge, and a cancelled alarm staying silent.

// File: rtl/alarm_timer64_pkg.sv
package alarm_timer64_pkg;

    localparam int DATA_W = 32;
    localparam int TIME_W = 64;

    // byte offsets of the register window
    localparam int OFS_TIME_LO   = 'h00;
    localparam int OFS_TIME_HI   = 'h04;
    localparam int OFS_ALARM_LO  = 'h08;
    localparam int OFS_ALARM_HI  = 'h0C;
    localparam int OFS_IRQ_ACK   = 'h10;
    localparam int OFS_CANCEL    = 'h14;

    typedef enum logic {
        ST_DISARMED = 1'b0,
        ST_ARMED    = 1'b1
    } arm_state_t;

    typedef struct packed {
        logic rd_time_lo;
        logic rd_time_hi;
        logic wr_alarm_lo;
        logic wr_alarm_hi;
        logic wr_irq_ack;
        logic wr_cancel;
        logic bad;
    } bus_cmd_t;

endpackage

// File: rtl/at_decode.sv
module at_decode
    import alarm_timer64_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output bus_cmd_t          cmd
);
    localparam logic [ADDR_W-1:0] A_TLO = ADDR_W'(OFS_TIME_LO);
    localparam logic [ADDR_W-1:0] A_THI = ADDR_W'(OFS_TIME_HI);
    localparam logic [ADDR_W-1:0] A_ALO = ADDR_W'(OFS_ALARM_LO);
    localparam logic [ADDR_W-1:0] A_AHI = ADDR_W'(OFS_ALARM_HI);
    localparam logic [ADDR_W-1:0] A_ACK = ADDR_W'(OFS_IRQ_ACK);
    localparam logic [ADDR_W-1:0] A_CAN = ADDR_W'(OFS_CANCEL);

    always_comb begin
        cmd = '0;
        if (sel) begin
            if (!wr) begin
                case (addr)
                    A_TLO:   cmd.rd_time_lo = 1'b1;
                    A_THI:   cmd.rd_time_hi = 1'b1;
                    default: cmd.bad        = 1'b1;
                endcase
            end else begin
                case (addr)
                    A_ALO:   cmd.wr_alarm_lo = 1'b1;
                    A_AHI:   cmd.wr_alarm_hi = 1'b1;
                    A_ACK:   cmd.wr_irq_ack  = 1'b1;
                    A_CAN:   cmd.wr_cancel   = 1'b1;
                    default: cmd.bad         = 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/at_timebase.sv
module at_timebase
    import alarm_timer64_pkg::*;
#(
    parameter logic [TIME_W-1:0] NS_PER_CLK = 64'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_snap,
    output logic [TIME_W-1:0] count,
    output logic [TIME_W-1:0] snap
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            snap  <= '0;
        end else begin
            count <= count + NS_PER_CLK;
            if (take_snap) snap <= count;
        end
    end
endmodule

// File: rtl/at_alarm_ctrl.sv
module at_alarm_ctrl
    import alarm_timer64_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bus_cmd_t          cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic [TIME_W-1:0] now,
    output arm_state_t        state,
    output logic [TIME_W-1:0] alarm,
    output logic              irq
);
    arm_state_t        state_d;
    logic [DATA_W-1:0] alarm_hi_q, alarm_lo_q;
    logic [TIME_W-1:0] alarm_new;
    logic              new_due, fire, irq_set, irq_clr;

    assign alarm     = {alarm_hi_q, alarm_lo_q};
    assign alarm_new = {alarm_hi_q, wdata};
    assign new_due   = $signed(alarm_new) <= $signed(now);
    assign fire      = (state == ST_ARMED) && ($signed(now) >= $signed(alarm))
                       && !cmd.wr_cancel && !cmd.wr_alarm_lo;

    // alarm value registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_hi_q <= '0;
            alarm_lo_q <= '0;
        end else begin
            if (cmd.wr_alarm_hi) alarm_hi_q <= wdata;
            if (cmd.wr_alarm_lo) alarm_lo_q <= wdata;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            ST_DISARMED: begin
                if (cmd.wr_alarm_lo && !new_due) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (cmd.wr_cancel)        state_d = ST_DISARMED;
                else if (cmd.wr_alarm_lo) state_d = new_due ? ST_DISARMED : ST_ARMED;
                else if (fire)            state_d = ST_DISARMED;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_DISARMED;
        else        state <= state_d;
    end

    // output register: interrupt level
    assign irq_set = (cmd.wr_alarm_lo && new_due) || fire;
    assign irq_clr = cmd.wr_irq_ack || cmd.wr_cancel;

    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (irq_set) irq <= 1'b1;
        else if (irq_clr) irq <= 1'b0;
    end
endmodule

// File: rtl/alarm_timer64.sv
module alarm_timer64
    import alarm_timer64_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [TIME_W-1:0] NS_PER_CLK = 64'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       rd_data,
    output logic              irq,
    output logic              err
);
    bus_cmd_t          cmd;
    logic [TIME_W-1:0] count_w, snap_w, alarm_w;
    arm_state_t        state_w;

    at_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel (bus_sel),
        .wr  (bus_wr),
        .addr(bus_addr),
        .cmd (cmd)
    );

    at_timebase #(.NS_PER_CLK(NS_PER_CLK)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_snap(cmd.rd_time_lo),
        .count    (count_w),
        .snap     (snap_w)
    );

    at_alarm_ctrl u_alm (
        .clk  (clk),
        .rst_n(rst_n),
        .cmd  (cmd),
        .wdata(bus_wdata),
        .now  (count_w),
        .state(state_w),
        .alarm(alarm_w),
        .irq  (irq)
    );

    // read data and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            err     <= 1'b0;
        end else begin
            err <= cmd.bad;
            if (cmd.rd_time_lo)       rd_data <= count_w[DATA_W-1:0];
            else if (cmd.rd_time_hi)  rd_data <= snap_w[TIME_W-1:DATA_W];
            else if (bus_sel && !bus_wr) rd_data <= '0;
        end
    end
endmodule

// File: rtl/alarm_timer64_sva.sv
module alarm_timer64_sva
    import alarm_timer64_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [TIME_W-1:0] NS_PER_CLK = 64'd1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       rd_data,
    input logic              irq,
    input logic              err,
    input logic [TIME_W-1:0] count,
    input logic [DATA_W-1:0] snap_hi,
    input logic [TIME_W-1:0] alarm,
    input arm_state_t        state
);
    logic wr_hi, wr_ack, wr_can, rd_hi;
    assign wr_hi  = bus_sel && bus_wr  && bus_addr == ADDR_W'(OFS_ALARM_HI);
    assign wr_ack = bus_sel && bus_wr  && bus_addr == ADDR_W'(OFS_IRQ_ACK);
    assign wr_can = bus_sel && bus_wr  && bus_addr == ADDR_W'(OFS_CANCEL);
    assign rd_hi  = bus_sel && !bus_wr && bus_addr == ADDR_W'(OFS_TIME_HI);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> count == $past(count) + NS_PER_CLK);

    assert_hi_from_snapshot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |=> rd_data == $past(snap_hi));

    assert_hi_write_no_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && state == ST_DISARMED) |=> (state == ST_DISARMED && irq == $past(irq)));

    assert_due_alarm_fires_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && $signed(count) >= $signed(alarm) && !bus_sel)
        |=> (state == ST_DISARMED && irq));

    assert_ack_drops_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && state == ST_DISARMED) |=> (!irq && state == ST_DISARMED));

    assert_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_can |=> (state == ST_DISARMED && !irq));

    assert_err_needs_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> !err);

endmodule

bind alarm_timer64 alarm_timer64_sva #(.ADDR_W(ADDR_W), .NS_PER_CLK(NS_PER_CLK)) u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .rd_data (rd_data),
    .irq     (irq),
    .err     (err),
    .count   (count_w),
    .snap_hi (snap_w[63:32]),
    .alarm   (alarm_w),
    .state   (state_w)
);

// File: tb/alarm_timer64_test.sv
module alarm_timer64_test;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [63:0] FAST_STEP = 64'h4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_data, rd_data_f;
    logic        irq, err, irq_f, err_f;
    int          checks = 0, errors = 0;
    longint      edges = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) if (rst_n) edges <= edges + 1;

    alarm_timer64 uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_data(rd_data), .irq(irq), .err(err)
    );

    alarm_timer64 #(.NS_PER_CLK(FAST_STEP)) uut_fast (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_data(rd_data_f), .irq(irq_f), .err(err_f)
    );

    // vector: wr, addr, wdata, check_rd, exp_rd, exp_irq, exp_err, req
    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic        chk_rd;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic        exp_err;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 12'h004, 32'h0,         1'b1, 32'h0, 1'b0, 1'b0, 8'd1},  // R1 snapshot zero
        '{1'b0, 12'h020, 32'h0,         1'b1, 32'h0, 1'b0, 1'b1, 8'd9},  // R9 unlisted read
        '{1'b0, 12'h008, 32'h0,         1'b1, 32'h0, 1'b0, 1'b1, 8'd9},  // R9 read of write-only
        '{1'b1, 12'h00C, 32'h8000_0000, 1'b0, 32'h0, 1'b0, 1'b0, 8'd4},  // R4 hi only
        '{1'b1, 12'h008, 32'h0,         1'b0, 32'h0, 1'b1, 1'b0, 8'd10}, // R10 negative alarm
        '{1'b1, 12'h00C, 32'h0,         1'b0, 32'h0, 1'b1, 1'b0, 8'd4},  // R4 irq untouched
        '{1'b1, 12'h010, 32'h0,         1'b0, 32'h0, 1'b0, 1'b0, 8'd7},  // R7 ack
        '{1'b1, 12'h00C, 32'hFFFF_FFFF, 1'b0, 32'h0, 1'b0, 1'b0, 8'd4},  // R4
        '{1'b1, 12'h008, 32'hFFFF_FFFF, 1'b0, 32'h0, 1'b1, 1'b0, 8'd10}, // R10 alarm -1
        '{1'b1, 12'h014, 32'h0,         1'b0, 32'h0, 1'b0, 1'b0, 8'd8},  // R8 cancel
        '{1'b1, 12'h000, 32'h1234,      1'b0, 32'h0, 1'b0, 1'b1, 8'd9},  // R9 write read-only
        '{1'b1, 12'h003, 32'h5,         1'b0, 32'h0, 1'b0, 1'b1, 8'd9},  // R9 unaligned
        '{1'b1, 12'h00C, 32'h0,         1'b0, 32'h0, 1'b0, 1'b0, 8'd4}   // R4 restore hi
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // called at a negedge, returns at the following negedge
    task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        longint t_rd, a_tm;
        logic   early;
        repeat (3) @(negedge clk);
        check("R1 irq", irq, 0);
        check("R1 err", err, 0);
        check("R1 rd_data", rd_data, 0);
        rst_n = 1'b1;

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            access(VECS[v].wr, VECS[v].addr, VECS[v].wdata);
            if (VECS[v].chk_rd) check($sformatf("R%0d rd_data v%0d", VECS[v].req, v), rd_data, VECS[v].exp_rd);
            check($sformatf("R%0d irq v%0d", VECS[v].req, v), irq, VECS[v].exp_irq);
            check($sformatf("R%0d err v%0d", VECS[v].req, v), err, VECS[v].exp_err);
        end
        idle(1);
        check("R9 err one cycle", err, 0);

        // R2: low read tracks elapsed clocks
        access(1'b0, 12'h000, 0);
        t_rd = edges - 1;
        check("R2 time low", rd_data, 64'(t_rd[31:0]));
        check("R2 fast time low", rd_data_f, 64'(32'(t_rd * FAST_STEP)));
        access(1'b0, 12'h000, 0);
        check("R2 step", rd_data, 64'(32'(t_rd + 1)));

        // R3: high half from snapshot while fast counter rolls over
        access(1'b0, 12'h000, 0);
        t_rd = edges - 1;
        idle(3);
        access(1'b0, 12'h004, 0);
        check("R3 snapshot high", rd_data_f, (t_rd * FAST_STEP) >> 32);

        // R5: alarm equal to current time fires at once, stays disarmed
        access(1'b1, 12'h008, 32'(edges));
        check("R5 immediate irq", irq, 1);
        access(1'b1, 12'h010, 0);
        idle(5);
        check("R5 not armed", irq, 0);

        // R6: future alarm fires exactly when due
        a_tm = edges + 9;
        access(1'b1, 12'h008, 32'(a_tm));
        early = 1'b0;
        while (edges < a_tm + 1) begin
            if (irq) early = 1'b1;
            idle(1);
        end
        check("R6 no early irq", early, 0);
        check("R6 fires when due", irq, 1);
        access(1'b1, 12'h010, 0);
        idle(10);
        check("R6 one shot", irq, 0);

        // R7: ack keeps alarm armed
        access(1'b1, 12'h008, 32'(edges));
        a_tm = edges + 12;
        access(1'b1, 12'h008, 32'(a_tm));
        check("R7 irq kept by arming", irq, 1);
        access(1'b1, 12'h010, 0);
        check("R7 ack", irq, 0);
        while (edges < a_tm + 1) idle(1);
        check("R7 still armed", irq, 1);
        access(1'b1, 12'h010, 0);

        // R8: cancel stops a pending alarm
        a_tm = edges + 6;
        access(1'b1, 12'h008, 32'(a_tm));
        access(1'b1, 12'h014, 0);
        idle(12);
        check("R8 cancelled", irq, 0);

        // R9: write to unlisted offset does not touch alarm
        a_tm = edges + 8;
        access(1'b1, 12'h008, 32'(a_tm));
        access(1'b1, 12'h018, 0);
        check("R9 ignored err", err, 1);
        while (edges < a_tm + 1) idle(1);
        check("R9 ignored write", irq, 1);

        // R4: hi write does not arm
        access(1'b1, 12'h014, 0);
        access(1'b1, 12'h00C, 32'h0000_0001);
        idle(4);
        check("R4 no arm", irq, 0);

        finish_run();
    end
endmodule